// File: doc/BRIEF.md
# Output voltage source selector

This block picks, for each of two regulator channels, where the output-voltage target comes from. One source is the management-bus target, supplied as a plain value. The other is the adaptive-voltage serial path, which delivers target values as commit strobes. A channel may only follow the adaptive path when its non-volatile permission bit is set and its live 4-bit control field holds the adaptive code.

A 2-bit non-volatile default code sets the value the live field reads after reset. That value holds until software first writes the field. When a channel hands control to the adaptive path, it does not carry the old voltage across. Its target drops to a parameterised low placeholder and stays there until a new adaptive command lands. Handing control back to the management bus takes up the present management target at once. Each change of source raises a one-cycle flag.

`rst_n` is asynchronous and active low. Its deassertion is expected to be synchronous to `clk`.

Top module: `vsrc_select`

## Requirements
- R1: While `rst_n` is low, `src_avs` and `src_chg` are 0 and each channel's `vout_tgt` slice equals its `mb_vout` slice.
- R2: When a channel's permission bit is 1 and its live field is 4'b1100, the channel's `src_avs` becomes 1. This takes effect on the second rising edge after the write strobe is sampled.
- R3: With the permission bit at 0, the channel stays on the management source even when the live field is 4'b1100.
- R4: A default code of 2'b10 makes the live field read 4'b1100 from reset until the first write. Any other default code makes it read 4'b0000. With 2'b10 and permission 1, the channel is on the adaptive source one edge after reset release.
- R5: A runtime write replaces the default-derived field value for good.
- R6: On entry to the adaptive source with no commit in that cycle, the target equals the LOW_V parameter (default 0).
- R7: A commit sampled while the adaptive source is selected sets the target to the committed value on the next cycle. Between commits the target holds.
- R8: Commits sampled while the management source is selected have no effect. A later handoff still starts at LOW_V.
- R9: Returning to the management source outputs the present `mb_vout` value in the same cycle that `src_avs` falls.
- R10: `src_chg` is high for exactly the one cycle in which `src_avs` takes a new value.
- R11: The two channels are independent. Writes, permission and commits of one leave the other's outputs unchanged.
- R12: A commit sampled in the handoff cycle is taken in place of LOW_V. Field values other than 4'b1100 (e.g. 4'b1101, 4'b1000) select the management source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_avs_en | input | NCH | Non-volatile adaptive-path permission, one bit per channel |
| nv_dflt | input | 2*NCH | Non-volatile default source code, 2 bits per channel |
| ctrl_wr | input | NCH | Live control field write strobe per channel |
| ctrl_wdata | input | 4 | Live control field write value |
| mb_vout | input | NCH*VW | Management-bus voltage target per channel |
| avs_commit | input | NCH | Adaptive voltage command commit strobe per channel |
| avs_vout | input | NCH*VW | Adaptive voltage command value per channel |
| vout_tgt | output | NCH*VW | Selected voltage target per channel |
| src_avs | output | NCH | 1 when the channel follows the adaptive path |
| src_chg | output | NCH | One-cycle pulse on a change of selected source |

## Verification
The main sequence steps channel A through several patterns.

- Entering the adaptive path with and without a simultaneous commit shows whether the placeholder or the commit wins.
- Commits that arrive while on the management source, followed by a fresh handoff, show whether a stale adaptive value leaks through.
- Clearing the permission bit while the field still holds the adaptive code, and writing near-miss codes, separate a full-code match from partial decoding.
- Reset with different default codes on the two channels, followed by writes and commits to channel B alone, separates default loading, override and channel crosstalk.

// File: rtl/vsrc_pkg.sv
package vsrc_pkg;
  localparam int unsigned CF_W = 4;
  localparam logic [CF_W-1:0] CF_AVS = 4'b1100;
  localparam logic [CF_W-1:0] CF_MB  = 4'b0000;
  localparam logic [1:0]      NV_AVS = 2'b10;

  // live field value implied by a non-volatile default code
  function automatic logic [CF_W-1:0] boot_field(input logic [1:0] code);
    return (code == NV_AVS) ? CF_AVS : CF_MB;
  endfunction
endpackage

// File: rtl/vsrc_field.sv
module vsrc_field
  import vsrc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      nv_dflt,
  input  logic            wr,
  input  logic [CF_W-1:0] wdata,
  output logic [CF_W-1:0] field
);
  logic            ovr_q, ovr_d;
  logic [CF_W-1:0] fld_q, fld_d;

  always_comb begin
    ovr_d = ovr_q;
    fld_d = fld_q;
    if (wr) begin
      ovr_d = 1'b1;
      fld_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      fld_q <= CF_MB;
    end else if (wr) begin
      ovr_q <= ovr_d;
      fld_q <= fld_d;
    end
  end

  // until the first write the field follows the non-volatile default
  assign field = ovr_q ? fld_q : boot_field(nv_dflt);
endmodule

// File: rtl/vsrc_chan.sv
module vsrc_chan
  import vsrc_pkg::*;
#(
  parameter int unsigned VW    = 8,
  parameter logic [VW-1:0] LOW_V = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CF_W-1:0] field,
  input  logic            commit,
  input  logic [VW-1:0]   avs_v,
  input  logic [VW-1:0]   mb_v,
  output logic [VW-1:0]   tgt,
  output logic            is_avs,
  output logic            chg
);
  logic          sel_d;
  logic          avs_q;
  logic          chg_q, chg_d;
  logic [VW-1:0] hold_q, hold_d;
  logic          hold_ce;

  always_comb begin
    sel_d   = en && (field == CF_AVS);
    chg_d   = sel_d != avs_q;
    hold_ce = 1'b0;
    hold_d  = hold_q;
    if (sel_d && commit) begin
      hold_ce = 1'b1;
      hold_d  = avs_v;
    end else if (sel_d && !avs_q) begin
      hold_ce = 1'b1;
      hold_d  = LOW_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avs_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      avs_q <= sel_d;
      chg_q <= chg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= LOW_V;
    else if (hold_ce) hold_q <= hold_d;
  end

  assign tgt    = avs_q ? hold_q : mb_v;
  assign is_avs = avs_q;
  assign chg    = chg_q;
endmodule

// File: rtl/vsrc_select.sv
module vsrc_select
  import vsrc_pkg::*;
#(
  parameter int unsigned   NCH   = 2,
  parameter int unsigned   VW    = 8,
  parameter logic [VW-1:0] LOW_V = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    nv_avs_en,
  input  logic [2*NCH-1:0]  nv_dflt,
  input  logic [NCH-1:0]    ctrl_wr,
  input  logic [CF_W-1:0]   ctrl_wdata,
  input  logic [NCH*VW-1:0] mb_vout,
  input  logic [NCH-1:0]    avs_commit,
  input  logic [NCH*VW-1:0] avs_vout,
  output logic [NCH*VW-1:0] vout_tgt,
  output logic [NCH-1:0]    src_avs,
  output logic [NCH-1:0]    src_chg
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CF_W-1:0] field;

    vsrc_field u_field (
      .clk     (clk),
      .rst_n   (rst_n),
      .nv_dflt (nv_dflt[2*c +: 2]),
      .wr      (ctrl_wr[c]),
      .wdata   (ctrl_wdata),
      .field   (field)
    );

    vsrc_chan #(.VW(VW), .LOW_V(LOW_V)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (nv_avs_en[c]),
      .field  (field),
      .commit (avs_commit[c]),
      .avs_v  (avs_vout[c*VW +: VW]),
      .mb_v   (mb_vout[c*VW +: VW]),
      .tgt    (vout_tgt[c*VW +: VW]),
      .is_avs (src_avs[c]),
      .chg    (src_chg[c])
    );
  end
endmodule

// File: rtl/vsrc_chk.sv
module vsrc_chk #(
  parameter int unsigned   NCH   = 2,
  parameter int unsigned   VW    = 8,
  parameter logic [VW-1:0] LOW_V = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    nv_avs_en,
  input logic [NCH-1:0]    avs_commit,
  input logic [NCH*VW-1:0] avs_vout,
  input logic [NCH*VW-1:0] mb_vout,
  input logic [NCH*VW-1:0] vout_tgt,
  input logic [NCH-1:0]    src_avs,
  input logic [NCH-1:0]    src_chg
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R3
    mb_when_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nv_avs_en[i] |=> !src_avs[i]);
    // R10
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_chg[i] |-> (src_avs[i] != $past(src_avs[i])));
    // R10
    chg_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_avs[i] != $past(src_avs[i])) |-> src_chg[i]);
    // R6
    entry_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(src_avs[i]) && !$past(avs_commit[i])) |-> (vout_tgt[i*VW +: VW] == LOW_V));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_avs[i] && $past(src_avs[i]) && !$past(avs_commit[i])) |-> $stable(vout_tgt[i*VW +: VW]));
    // R7
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_avs[i] && $past(src_avs[i]) && $past(avs_commit[i]))
        |-> (vout_tgt[i*VW +: VW] == $past(avs_vout[i*VW +: VW])));
    // R9
    back_mb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(src_avs[i]) |-> (vout_tgt[i*VW +: VW] == mb_vout[i*VW +: VW]));
  end
endmodule

bind vsrc_select vsrc_chk #(.NCH(NCH), .VW(VW), .LOW_V(LOW_V)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nv_avs_en  (nv_avs_en),
  .avs_commit (avs_commit),
  .avs_vout   (avs_vout),
  .mb_vout    (mb_vout),
  .vout_tgt   (vout_tgt),
  .src_avs    (src_avs),
  .src_chg    (src_chg)
);

// File: tb/sim_vsrc_select.sv
module sim_vsrc_select;
  localparam int NCH = 2;
  localparam int VW  = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      nv_avs_en;
  logic [3:0]      nv_dflt;
  logic [1:0]      ctrl_wr;
  logic [3:0]      ctrl_wdata;
  logic [15:0]     mb_vout;
  logic [1:0]      avs_commit;
  logic [15:0]     avs_vout;
  logic [15:0]     vout_tgt;
  logic [1:0]      src_avs;
  logic [1:0]      src_chg;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vsrc_select #(.NCH(NCH), .VW(VW), .LOW_V(8'h00)) u0 (
    .clk(clk), .rst_n(rst_n), .nv_avs_en(nv_avs_en), .nv_dflt(nv_dflt),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .mb_vout(mb_vout),
    .avs_commit(avs_commit), .avs_vout(avs_vout), .vout_tgt(vout_tgt),
    .src_avs(src_avs), .src_chg(src_chg)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] wd;
    logic       en;
    logic       cm;
    logic [7:0] av;
    logic [7:0] mb;
    logic       esrc;
    logic       echg;
    logic [7:0] ev;
  } vec_t;

  // channel A sequence; expected outputs sampled after the step's edge
  localparam vec_t TBL [17] = '{
    '{1'b1, 4'hC, 1'b1, 1'b0, 8'h00, 8'h40, 1'b0, 1'b0, 8'h40},  // R2 write
    '{1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h41, 1'b1, 1'b1, 8'h00},  // R6 entry low
    '{1'b0, 4'h0, 1'b1, 1'b1, 8'h55, 8'h42, 1'b1, 1'b0, 8'h55},  // R7 commit
    '{1'b0, 4'h0, 1'b1, 1'b0, 8'h66, 8'h43, 1'b1, 1'b0, 8'h55},  // R7 hold
    '{1'b0, 4'h0, 1'b1, 1'b1, 8'h77, 8'h44, 1'b1, 1'b0, 8'h77},  // R7 commit
    '{1'b1, 4'h0, 1'b1, 1'b0, 8'h00, 8'h44, 1'b1, 1'b0, 8'h77},  // R5 write mb
    '{1'b0, 4'h0, 1'b1, 1'b1, 8'h99, 8'h45, 1'b0, 1'b1, 8'h45},  // R9 back
    '{1'b0, 4'h0, 1'b1, 1'b1, 8'hAA, 8'h46, 1'b0, 1'b0, 8'h46},  // R8 ignored
    '{1'b1, 4'hC, 1'b1, 1'b0, 8'h00, 8'h47, 1'b0, 1'b0, 8'h47},
    '{1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h48, 1'b1, 1'b1, 8'h00},  // R8 no stale
    '{1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h49, 1'b0, 1'b1, 8'h49},  // R3 disabled
    '{1'b0, 4'h0, 1'b0, 1'b1, 8'hBB, 8'h4A, 1'b0, 1'b0, 8'h4A},  // R3
    '{1'b0, 4'h0, 1'b1, 1'b1, 8'hCC, 8'h4B, 1'b1, 1'b1, 8'hCC},  // R12 commit on entry
    '{1'b1, 4'hD, 1'b1, 1'b0, 8'h00, 8'h4C, 1'b1, 1'b0, 8'hCC},
    '{1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h4D, 1'b0, 1'b1, 8'h4D},  // R12 1101 -> mb
    '{1'b1, 4'h8, 1'b1, 1'b0, 8'h00, 8'h4E, 1'b0, 1'b0, 8'h4E},
    '{1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h4F, 1'b0, 1'b0, 8'h4F}   // R12 1000 -> mb
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; nv_avs_en = 2'b00; nv_dflt = 4'b0000;
    ctrl_wr = 2'b00; ctrl_wdata = 4'h0; mb_vout = 16'h2140;
    avs_commit = 2'b00; avs_vout = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 src_avs", {14'd0, src_avs}, 16'd0);
    chk("R1 src_chg", {14'd0, src_chg}, 16'd0);
    chk("R1 vout", vout_tgt, 16'h2140);
    rst_n = 1'b1;

    foreach (TBL[k]) begin
      ctrl_wr[0]     = TBL[k].wr;
      ctrl_wdata     = TBL[k].wd;
      nv_avs_en[0]   = TBL[k].en;
      avs_commit[0]  = TBL[k].cm;
      avs_vout[7:0]  = TBL[k].av;
      mb_vout[7:0]   = TBL[k].mb;
      step();
      chk($sformatf("R2 src row %0d", k), {15'd0, src_avs[0]}, {15'd0, TBL[k].esrc});
      chk($sformatf("R10 chg row %0d", k), {15'd0, src_chg[0]}, {15'd0, TBL[k].echg});
      chk($sformatf("R6 vout row %0d", k), {8'd0, vout_tgt[7:0]}, {8'd0, TBL[k].ev});
      // R11 channel B untouched all along
      chk($sformatf("R11 chB row %0d", k), {src_avs[1], vout_tgt[15:8]}, {1'b0, 8'h21});
    end
    ctrl_wr = 2'b00; avs_commit = 2'b00;

    // R4: default code 10b on A, 01b on B, both permitted
    rst_n = 1'b0; nv_dflt = 4'b0110; nv_avs_en = 2'b11;
    mb_vout = 16'h3050; avs_vout = 16'h0;
    step();
    rst_n = 1'b1;
    step();
    chk("R4 A adaptive", {15'd0, src_avs[0]}, 16'd1);
    chk("R4 A chg", {15'd0, src_chg[0]}, 16'd1);
    chk("R4 A low", {8'd0, vout_tgt[7:0]}, 16'h0000);
    chk("R4 B mb", {src_avs[1], vout_tgt[15:8]}, {1'b0, 8'h30});
    step();
    chk("R10 A chg drops", {15'd0, src_chg[0]}, 16'd0);

    // R5: override default with management code
    ctrl_wr = 2'b01; ctrl_wdata = 4'h0;
    step();
    ctrl_wr = 2'b00;
    chk("R5 A before", {15'd0, src_avs[0]}, 16'd1);
    step();
    chk("R5 A mb", {7'd0, src_avs[0], vout_tgt[7:0]}, {7'd0, 1'b0, 8'h50});
    nv_dflt = 4'b0110;
    step();
    chk("R5 A stays mb", {15'd0, src_avs[0]}, 16'd0);

    // R11: channel B alone to adaptive path
    ctrl_wr = 2'b10; ctrl_wdata = 4'hC;
    step();
    ctrl_wr = 2'b00;
    step();
    chk("R11 B adaptive", {src_avs, vout_tgt[15:8]}, {2'b10, 8'h00});
    avs_commit = 2'b10; avs_vout = 16'h3C99;
    step();
    avs_commit = 2'b00;
    chk("R11 B commit", vout_tgt, 16'h3C50);
    chk("R11 A unchanged", {14'd0, src_avs}, 16'd2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule